// File: doc/BRIEF.md
# Byte-Oriented File-Register Execute Unit

This unit executes two byte-wide operations on a file-register datapath: subtract-with-borrow and nibble swap. The datapath has an 8-bit working register W, a bank select register, a status register and an internal data-memory model. Each instruction takes four clock phases. In the first phase the 16-bit word is decoded. In the second the operand is read from data memory. In the third the result and the flags are formed. In the fourth the result and flags are committed. The phase counter runs freely from reset, and an instruction is taken only in the decode phase.

The operand address comes from the 8-bit register field of the word and one of three sources. With the access bit set, the bank select register supplies the upper bits. With the access bit clear, the access bank is used. With the access bit clear, extended mode on and a field value of 5Fh or less, the address is an index register plus the field. A load port lets the surrounding logic preset W, the bank select register, the status register or any data byte while no instruction is in flight. A peek port reads any data byte back.

Top module: `fbyte_exec`

## Requirements
- R1: After reset, W reads 00h, the status register reads 00h and the phase output reads 0.
- R2: The phase output steps 0,1,2,3,0 on each clock. A word is accepted only when `instr_valid` is high in phase 0. Its result is visible after the fourth rising edge that follows acceptance. `instr_valid` in any other phase has no effect.
- R3: Subtract-with-borrow (word bits [15:10] = 010110) computes f − W − (1 − C) modulo 256, where C is status bit 0.
- R4: After subtract-with-borrow, C (status bit 0) is 1 when no borrow leaves bit 7 and 0 otherwise. DC (status bit 1) has the same inverted sense for the borrow out of bit 3.
- R5: After subtract-with-borrow, Z (status bit 2) is 1 when the result is 00h. OV (status bit 3) is the signed overflow of the subtraction. N (status bit 4) copies result bit 7. Status bits 7:5 read 0.
- R6: Nibble swap (word bits [15:10] = 001110) produces {f[3:0], f[7:4]} and leaves the whole status register unchanged.
- R7: With word bit 9 (d) = 0 the result goes to W and the data byte is unchanged. With d = 1 the result is written back to the data byte and W is unchanged.
- R8: With word bit 8 (a) = 1 the data address is {bank select, f}.
- R9: With a = 0 and the indexed path not taken, f below 60h addresses 0f'h and f of 60h or more addresses F00h + f.
- R10: With a = 0, `ext_en` = 1 and f ≤ 5Fh, the address is (`idx_reg` + f) modulo 4096. With f ≥ 60h the access bank still applies.
- R11: A word whose bits [15:10] match neither opcode changes no W, status or data byte.
- R12: The load port (select 0 data byte, 1 W, 2 bank select, 3 status) writes on a clock edge with no instruction in flight. A load issued while an instruction is in flight is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| instr | input | 16 | Instruction word |
| instr_valid | input | 1 | Word present; sampled in phase 0 |
| ext_en | input | 1 | Extended addressing mode enable |
| idx_reg | input | 12 | Index register for indexed-offset addressing |
| ld_en | input | 1 | Load port strobe |
| ld_sel | input | 2 | Load target: 0 data, 1 W, 2 bank select, 3 status |
| ld_addr | input | 12 | Data address for a data-byte load |
| ld_data | input | 8 | Load value |
| peek_addr | input | 12 | Data address for read-back |
| peek_data | output | 8 | Data byte at `peek_addr` |
| w_q | output | 8 | Working register |
| status_q | output | 8 | Status register {000, N, OV, Z, DC, C} |
| bsr_q | output | 4 | Bank select register |
| phase | output | 2 | Current phase, 0 = decode |

## Verification
The hardest case to reach is a load that arrives while an instruction is in flight. The load must be dropped, yet it lands in a phase the bench does not normally drive. The bench issues a word, waits one cycle into the read phase, strobes a W load, and then checks that W still holds its value from before the instruction. A second timing corner is `instr_valid` asserted only outside phase 0. The bench drives a valid word for a single phase-1 cycle and confirms that no state moves. For indexed addressing, the bench loads the direct-access alias of the same field with a different value. It then checks that the indexed byte changed and the alias did not, both at the boundary field 5Fh and with the index sum wrapping past FFFh.

// File: rtl/fbyte_pkg.sv
package fbyte_pkg;
   localparam int DATA_W = 8;
   localparam int INSTR_W = 16;

   typedef enum logic [1:0] {PH_DEC = 2'd0, PH_RD = 2'd1, PH_PROC = 2'd2, PH_WR = 2'd3} phase_t;
   typedef enum logic [1:0] {LD_FILE = 2'd0, LD_W = 2'd1, LD_BANK = 2'd2, LD_STAT = 2'd3} ld_sel_t;
   typedef enum logic {OP_SUBB = 1'b0, OP_SWAP = 1'b1} op_t;

   localparam logic [5:0] OPC_SUBB = 6'b010110;
   localparam logic [5:0] OPC_SWAP = 6'b001110;

   typedef struct packed {
      logic n;
      logic ov;
      logic z;
      logic dc;
      logic c;
   } flags_t;
endpackage

// File: rtl/fbyte_addr_gen.sv
module fbyte_addr_gen #(
   parameter int BANK_W = 4,
   parameter bit IDX_MODE = 1'b1,
   parameter logic [7:0] ACC_SPLIT = 8'h60
) (
   input  logic [7:0]          fld,
   input  logic                acc_bit,
   input  logic                ext_en,
   input  logic [BANK_W-1:0]   bank,
   input  logic [BANK_W+7:0]   idx,
   output logic [BANK_W+7:0]   addr
);
   localparam int AW = BANK_W + 8;

   logic [AW-1:0] acc_addr;
   logic          low_half;

   assign low_half = (fld < ACC_SPLIT);
   assign acc_addr = low_half ? {{BANK_W{1'b0}}, fld} : {{BANK_W{1'b1}}, fld};

   generate
      if (IDX_MODE) begin : g_idx
         logic [AW-1:0] idx_addr;
         assign idx_addr = idx + {{BANK_W{1'b0}}, fld};
         always_comb begin
            if (acc_bit)                   addr = {bank, fld};
            else if (ext_en && low_half)   addr = idx_addr;
            else                           addr = acc_addr;
         end
      end else begin : g_noidx
         logic unused_idx;
         assign unused_idx = ext_en ^ (^idx);
         always_comb addr = acc_bit ? {bank, fld} : acc_addr;
      end
   endgenerate
endmodule

// File: rtl/fbyte_alu.sv
module fbyte_alu
   import fbyte_pkg::*;
(
   input  op_t               op,
   input  logic [DATA_W-1:0] fval,
   input  logic [DATA_W-1:0] wval,
   input  logic              cin,
   output logic [DATA_W-1:0] res,
   output flags_t            flg
);
   logic [DATA_W:0] wide;
   logic [4:0]      nib;
   logic            bw;

   assign bw   = ~cin;
   assign wide = {1'b0, fval} - {1'b0, wval} - {{DATA_W{1'b0}}, bw};
   assign nib  = {1'b0, fval[3:0]} - {1'b0, wval[3:0]} - {4'b0, bw};

   always_comb begin
      if (op == OP_SWAP) begin
         res = {fval[3:0], fval[7:4]};
         flg = '0;
      end else begin
         res    = wide[DATA_W-1:0];
         flg.c  = ~wide[DATA_W];
         flg.dc = ~nib[4];
         flg.z  = (wide[DATA_W-1:0] == '0);
         flg.n  = wide[DATA_W-1];
         flg.ov = (fval[DATA_W-1] != wval[DATA_W-1]) && (wide[DATA_W-1] != fval[DATA_W-1]);
      end
   end
endmodule

// File: rtl/fbyte_regfile.sv
module fbyte_regfile #(
   parameter int AW = 12,
   parameter int DW = 8
) (
   input  logic          clk,
   input  logic          we,
   input  logic [AW-1:0] waddr,
   input  logic [DW-1:0] wdata,
   input  logic [AW-1:0] raddr_a,
   output logic [DW-1:0] rdata_a,
   input  logic [AW-1:0] raddr_b,
   output logic [DW-1:0] rdata_b
);
   localparam int DEPTH = 1 << AW;

   logic [DW-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   assign rdata_a = mem[raddr_a];
   assign rdata_b = mem[raddr_b];
endmodule

// File: rtl/fbyte_exec.sv
module fbyte_exec
   import fbyte_pkg::*;
#(
   parameter int BANK_W = 4,
   parameter bit IDX_MODE = 1'b1,
   parameter logic [7:0] ACC_SPLIT = 8'h60
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [15:0]          instr,
   input  logic                 instr_valid,
   input  logic                 ext_en,
   input  logic [BANK_W+7:0]    idx_reg,
   input  logic                 ld_en,
   input  logic [1:0]           ld_sel,
   input  logic [BANK_W+7:0]    ld_addr,
   input  logic [7:0]           ld_data,
   input  logic [BANK_W+7:0]    peek_addr,
   output logic [7:0]           peek_data,
   output logic [7:0]           w_q,
   output logic [7:0]           status_q,
   output logic [BANK_W-1:0]    bsr_q,
   output logic [1:0]           phase
);
   localparam int AW = BANK_W + 8;
   localparam int FLG_W = $bits(flags_t);

   generate
      if (BANK_W < 1 || BANK_W > 8) begin : g_bad_bank
         $error("BANK_W must lie in 1..8");
      end
      if (ACC_SPLIT == 8'h00) begin : g_bad_split
         $error("ACC_SPLIT must be nonzero");
      end
   endgenerate

   phase_t              ph;
   logic                busy;
   logic [15:0]         ir;
   op_t                 op;
   logic [AW-1:0]       ea, ea_q;
   logic [7:0]          opnd, res_q, alu_res;
   flags_t              alu_flg, flg_q;
   logic                dec_sub, dec_swap, dec_ok;
   logic                ld_take, exec_wr;
   logic                rf_we;
   logic [AW-1:0]       rf_waddr;
   logic [7:0]          rf_wdata, rf_rd;

   assign dec_sub  = (instr[15:10] == OPC_SUBB);
   assign dec_swap = (instr[15:10] == OPC_SWAP);
   assign dec_ok   = dec_sub | dec_swap;
   assign ld_take  = ld_en && !busy;
   assign exec_wr  = busy && (ph == PH_WR);

   fbyte_addr_gen #(.BANK_W(BANK_W), .IDX_MODE(IDX_MODE), .ACC_SPLIT(ACC_SPLIT)) u_agen (
      .fld(ir[7:0]), .acc_bit(ir[8]), .ext_en(ext_en), .bank(bsr_q), .idx(idx_reg), .addr(ea)
   );

   fbyte_alu u_alu (
      .op(op), .fval(opnd), .wval(w_q), .cin(status_q[0]), .res(alu_res), .flg(alu_flg)
   );

   always_comb begin
      rf_we    = 1'b0;
      rf_waddr = ld_addr;
      rf_wdata = ld_data;
      if (exec_wr && ir[9]) begin
         rf_we    = 1'b1;
         rf_waddr = ea_q;
         rf_wdata = res_q;
      end else if (ld_take && ld_sel == LD_FILE) begin
         rf_we = 1'b1;
      end
   end

   fbyte_regfile #(.AW(AW), .DW(8)) u_rf (
      .clk(clk), .we(rf_we), .waddr(rf_waddr), .wdata(rf_wdata),
      .raddr_a(ea), .rdata_a(rf_rd), .raddr_b(peek_addr), .rdata_b(peek_data)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ph       <= PH_DEC;
         busy     <= 1'b0;
         ir       <= '0;
         op       <= OP_SUBB;
         ea_q     <= '0;
         opnd     <= '0;
         res_q    <= '0;
         flg_q    <= '0;
         w_q      <= '0;
         status_q <= '0;
         bsr_q    <= '0;
      end else begin
         ph <= phase_t'(ph + 2'd1);
         case (ph)
            PH_DEC: if (instr_valid && dec_ok) begin
               ir   <= instr;
               op   <= dec_swap ? OP_SWAP : OP_SUBB;
               busy <= 1'b1;
            end
            PH_RD: if (busy) begin
               opnd <= rf_rd;
               ea_q <= ea;
            end
            PH_PROC: if (busy) begin
               res_q <= alu_res;
               flg_q <= alu_flg;
            end
            PH_WR: if (busy) begin
               busy <= 1'b0;
               if (!ir[9]) w_q <= res_q;
               if (op == OP_SUBB) status_q <= {{(8-FLG_W){1'b0}}, flg_q};
            end
            default: ;
         endcase
         if (ld_take) begin
            case (ld_sel)
               LD_W:    w_q      <= ld_data;
               LD_BANK: bsr_q    <= ld_data[BANK_W-1:0];
               LD_STAT: status_q <= {{(8-FLG_W){1'b0}}, ld_data[FLG_W-1:0]};
               default: ;
            endcase
         end
      end
   end

   assign phase = ph;

   // R2: a word offered outside the decode phase never starts an instruction
   assert_accept_q1_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && ph != PH_DEC) |=> !busy);

   // R4: status moves only on an instruction commit or a status load
   assert_flags_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!exec_wr && !(ld_take && ld_sel == LD_STAT)) |=> $stable(status_q));

   // R5: Z reflects a subtraction result that went to W
   assert_zero_flag_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_wr && op == OP_SUBB && !ir[9]) |=> (status_q[2] == (w_q == 8'h00)));

   // R6: a nibble swap leaves status untouched
   assert_swap_keeps_flags_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (exec_wr && op == OP_SWAP) |=> $stable(status_q));

   // R11: an unrecognised word never starts an instruction
   assert_bad_op_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (ph == PH_DEC && !busy && instr_valid && !dec_ok) |=> !busy);

   // R12: W changes only at a commit to W or a W load while idle
   assert_w_guard_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!(exec_wr && !ir[9]) && !(ld_take && ld_sel == LD_W)) |=> $stable(w_q));
endmodule

// File: tb/fbyte_exec_bench.sv
`timescale 1ns/1ps
module fbyte_exec_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [15:0] instr = '0;
   logic        instr_valid = 1'b0;
   logic        ext_en = 1'b0;
   logic [11:0] idx_reg = '0;
   logic        ld_en = 1'b0;
   logic [1:0]  ld_sel = '0;
   logic [11:0] ld_addr = '0;
   logic [7:0]  ld_data = '0;
   logic [11:0] peek_addr = '0;
   logic [7:0]  peek_data, w_q, status_q;
   logic [3:0]  bsr_q;
   logic [1:0]  phase;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   fbyte_exec u_fbyte_exec (
      .clk(clk), .rst_n(rst_n), .instr(instr), .instr_valid(instr_valid), .ext_en(ext_en),
      .idx_reg(idx_reg), .ld_en(ld_en), .ld_sel(ld_sel), .ld_addr(ld_addr), .ld_data(ld_data),
      .peek_addr(peek_addr), .peek_data(peek_data), .w_q(w_q), .status_q(status_q),
      .bsr_q(bsr_q), .phase(phase)
   );

   task automatic chk(input string tag, input logic [15:0] got, input logic [15:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_bad++;
         $display("FAIL %s: got %h expected %h", tag, got, exp);
      end
   endtask

   // expected subtract-with-borrow from the requirements: {status, result}
   function automatic logic [15:0] model_sub(input logic [7:0] f, input logic [7:0] w, input logic c);
      logic [8:0] full;
      logic [4:0] low;
      logic [7:0] r;
      logic [7:0] st;
      full = {1'b0, f} - {1'b0, w} - (c ? 9'd0 : 9'd1);
      low  = {1'b0, f[3:0]} - {1'b0, w[3:0]} - (c ? 5'd0 : 5'd1);
      r = full[7:0];
      st = 8'h00;
      st[0] = ~full[8];
      st[1] = ~low[4];
      st[2] = (r == 8'h00);
      st[3] = (f[7] != w[7]) && (r[7] != f[7]);
      st[4] = r[7];
      return {st, r};
   endfunction

   task automatic load(input logic [1:0] sel, input logic [11:0] a, input logic [7:0] d);
      @(negedge clk);
      ld_en = 1'b1; ld_sel = sel; ld_addr = a; ld_data = d;
      @(negedge clk);
      ld_en = 1'b0;
   endtask

   function automatic logic [7:0] peek(input logic [11:0] a);
      return 8'h00;
   endfunction

   task automatic read_mem(input logic [11:0] a, output logic [7:0] v);
      peek_addr = a;
      #0.1;
      v = peek_data;
   endtask

   task automatic issue(input logic [15:0] w);
      @(negedge clk);
      while (phase != 2'd0) @(negedge clk);
      instr = w; instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0;
      repeat (3) @(negedge clk);
   endtask

   task automatic t_reset;
      chk("R1 W", {8'h0, w_q}, 16'h0000);
      chk("R1 status", {8'h0, status_q}, 16'h0000);
      chk("R1 phase", {14'h0, phase}, 16'h0000);
      @(negedge clk); chk("R2 phase step 1", {14'h0, phase}, 16'h0001);
      @(negedge clk); chk("R2 phase step 2", {14'h0, phase}, 16'h0002);
      @(negedge clk); chk("R2 phase step 3", {14'h0, phase}, 16'h0003);
      @(negedge clk); chk("R2 phase wrap", {14'h0, phase}, 16'h0000);
   endtask

   task automatic t_sub_banked;
      logic [15:0] e; logic [7:0] v;
      load(2'd2, 12'h000, 8'h02);
      load(2'd0, 12'h219, 8'h19);
      load(2'd1, 12'h000, 8'h0D);
      load(2'd3, 12'h000, 8'h01);
      e = model_sub(8'h19, 8'h0D, 1'b1);
      issue(16'h5B19);
      read_mem(12'h219, v);
      chk("R3 R8 banked result", {8'h0, v}, {8'h0, e[7:0]});
      chk("R3 expected 0C", {8'h0, v}, 16'h000C);
      chk("R4 status", {8'h0, status_q}, {8'h0, e[15:8]});
      chk("R7 W kept", {8'h0, w_q}, 16'h000D);
   endtask

   task automatic t_sub_zero;
      logic [15:0] e; logic [7:0] v;
      load(2'd0, 12'h025, 8'h1B);
      load(2'd1, 12'h000, 8'h1A);
      load(2'd3, 12'h000, 8'h00);
      e = model_sub(8'h1B, 8'h1A, 1'b0);
      issue(16'h5A25);
      read_mem(12'h025, v);
      chk("R9 R3 zero result", {8'h0, v}, 16'h0000);
      chk("R5 Z and C set", {8'h0, status_q}, {8'h0, e[15:8]});
      chk("R5 Z bit", {15'h0, status_q[2]}, 16'h0001);
   endtask

   task automatic t_sub_neg;
      logic [15:0] e; logic [7:0] v;
      load(2'd0, 12'hF80, 8'h03);
      load(2'd1, 12'h000, 8'h0E);
      load(2'd3, 12'h000, 8'h01);
      e = model_sub(8'h03, 8'h0E, 1'b1);
      issue(16'h5880);
      read_mem(12'hF80, v);
      chk("R7 R3 W gets F5", {8'h0, w_q}, 16'h00F5);
      chk("R9 R7 high access byte kept", {8'h0, v}, 16'h0003);
      chk("R5 N set C clear", {8'h0, status_q}, {8'h0, e[15:8]});
      chk("R4 C clear on borrow", {15'h0, status_q[0]}, 16'h0000);
   endtask

   task automatic t_ov_dc;
      logic [15:0] e;
      load(2'd0, 12'h040, 8'h80);
      load(2'd1, 12'h000, 8'h01);
      load(2'd3, 12'h000, 8'h01);
      e = model_sub(8'h80, 8'h01, 1'b1);
      issue(16'h5840);
      chk("R3 W 7F", {8'h0, w_q}, 16'h007F);
      chk("R5 OV", {8'h0, status_q}, {8'h0, e[15:8]});
      chk("R5 OV bit", {15'h0, status_q[3]}, 16'h0001);
      load(2'd0, 12'h041, 8'h10);
      load(2'd1, 12'h000, 8'h01);
      load(2'd3, 12'h000, 8'h01);
      e = model_sub(8'h10, 8'h01, 1'b1);
      issue(16'h5841);
      chk("R3 W 0F", {8'h0, w_q}, 16'h000F);
      chk("R4 DC borrow", {8'h0, status_q}, {8'h0, e[15:8]});
      chk("R4 DC bit clear", {15'h0, status_q[1]}, 16'h0000);
   endtask

   task automatic t_swap;
      logic [7:0] v;
      load(2'd2, 12'h000, 8'h05);
      load(2'd0, 12'h5AA, 8'h53);
      load(2'd3, 12'h000, 8'h15);
      issue(16'h3BAA);
      read_mem(12'h5AA, v);
      chk("R6 R8 swap 53", {8'h0, v}, 16'h0035);
      chk("R6 status kept", {8'h0, status_q}, 16'h0015);
      load(2'd0, 12'h031, 8'hC7);
      issue(16'h3831);
      read_mem(12'h031, v);
      chk("R7 swap to W", {8'h0, w_q}, 16'h007C);
      chk("R7 byte kept", {8'h0, v}, 16'h00C7);
   endtask

   task automatic t_indexed;
      logic [7:0] v;
      ext_en = 1'b1; idx_reg = 12'h300;
      load(2'd0, 12'h310, 8'h9A);
      load(2'd0, 12'h010, 8'h44);
      issue(16'h3A10);
      read_mem(12'h310, v); chk("R10 indexed byte", {8'h0, v}, 16'h00A9);
      read_mem(12'h010, v); chk("R10 alias kept", {8'h0, v}, 16'h0044);
      load(2'd0, 12'h35F, 8'h0F);
      load(2'd0, 12'h05F, 8'h66);
      issue(16'h3A5F);
      read_mem(12'h35F, v); chk("R10 boundary 5F", {8'h0, v}, 16'h00F0);
      read_mem(12'h05F, v); chk("R10 boundary alias", {8'h0, v}, 16'h0066);
      load(2'd0, 12'hF70, 8'h12);
      issue(16'h3A70);
      read_mem(12'hF70, v); chk("R10 R9 f=70 access", {8'h0, v}, 16'h0021);
      idx_reg = 12'hFF0;
      load(2'd0, 12'h010, 8'h4B);
      issue(16'h3A20);
      read_mem(12'h010, v); chk("R10 index wrap", {8'h0, v}, 16'h00B4);
      ext_en = 1'b0;
      load(2'd0, 12'h020, 8'h81);
      issue(16'h3A20);
      read_mem(12'h020, v); chk("R9 ext off direct", {8'h0, v}, 16'h0018);
   endtask

   task automatic t_bad_op;
      logic [7:0] v; logic [7:0] w0, s0, m0;
      load(2'd2, 12'h000, 8'h02);
      load(2'd0, 12'h219, 8'h5E);
      load(2'd1, 12'h000, 8'h33);
      load(2'd3, 12'h000, 8'h0A);
      w0 = w_q; s0 = status_q; read_mem(12'h219, m0);
      issue(16'h5D19);
      issue(16'h3919 ^ 16'h0400);
      read_mem(12'h219, v);
      chk("R11 W", {8'h0, w_q}, {8'h0, w0});
      chk("R11 status", {8'h0, status_q}, {8'h0, s0});
      chk("R11 byte", {8'h0, v}, {8'h0, m0});
   endtask

   task automatic t_valid_off_phase;
      logic [7:0] v;
      @(negedge clk);
      while (phase != 2'd1) @(negedge clk);
      instr = 16'h5919; instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0;
      repeat (6) @(negedge clk);
      read_mem(12'h219, v);
      chk("R2 off-phase W", {8'h0, w_q}, 16'h0033);
      chk("R2 off-phase byte", {8'h0, v}, 16'h005E);
   endtask

   task automatic t_load_busy;
      logic [7:0] v;
      load(2'd0, 12'h219, 8'h40);
      load(2'd1, 12'h000, 8'h10);
      load(2'd3, 12'h000, 8'h01);
      @(negedge clk);
      while (phase != 2'd0) @(negedge clk);
      instr = 16'h5B19; instr_valid = 1'b1;
      @(negedge clk);
      instr_valid = 1'b0;
      ld_en = 1'b1; ld_sel = 2'd1; ld_data = 8'hAA;
      @(negedge clk);
      ld_en = 1'b0;
      repeat (2) @(negedge clk);
      read_mem(12'h219, v);
      chk("R12 load dropped while busy", {8'h0, w_q}, 16'h0010);
      chk("R12 result", {8'h0, v}, 16'h0030);
      load(2'd1, 12'h000, 8'h5C);
      chk("R12 load idle", {8'h0, w_q}, 16'h005C);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      t_reset();
      t_sub_banked();
      t_sub_zero();
      t_sub_neg();
      t_ov_dc();
      t_swap();
      t_indexed();
      t_bad_op();
      t_valid_off_phase();
      t_load_busy();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
         end
      join_any
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule